// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind a receive MAC and places each incoming Ethernet frame into a circular buffer in local memory. Frame bytes arrive one per beat on a valid/ready stream. The FCS is included in the stream, and the frame's error and address-class flags are sampled on the last beat. The block packs the bytes into 32-bit little-endian words and writes them to the ring. Only after the payload is complete does it write a 32-bit header word at the start of the entry, holding a receive status in its low half and the byte count in its high half. It then advances its write offset.

Software consumes entries and reports its progress by writing its read position minus 16 into a 16-bit register. The block compares the two positions to drive a buffer-empty flag. It drops any frame that would overtake unread data, and any frame longer than a fixed cap. Each drop raises a sticky status bit and bumps a missed-frame counter. A committed entry raises a receive-done bit. Software clears the status bits by writing 1.

Back-pressure rules: a byte moves on a cycle where both `s_valid` and `s_ready` are high. `s_ready` falls for exactly one cycle after the last byte of a frame that is committed, while the header is written. A producer must hold its byte and flags stable while `s_ready` is low.

Top module: `rxr_writer`

## Requirements
- R1: `s_ready` is high out of reset and while bytes are taken, and is low for the single cycle after the last byte of a committed frame.
- R2: An entry starts with a header word at the entry start, with bits 15:0 the status and bits 31:16 the byte count including FCS. Payload byte k goes to byte offset 4+k, little-endian within each word. All writes are whole aligned 32-bit words, and the bytes of the final word past the frame end are zero.
- R3: Status bits: 1 alignment error, 2 CRC error, 3 count above MAX_LEN (1518), 4 count below MIN_LEN (64), 5 symbol error, 13 broadcast, 14 own-address match, 15 multicast. Bit 0 is set exactly when bits 1 to 5 are all clear.
- R4: The ring length is 8192 shifted left by `cfg_len_idx` (index 3 acts as 2). The next entry starts at (start + ((count+7) rounded down to a multiple of 4)) modulo the ring length, and payload addresses wrap modulo the ring length.
- R5: The header is written after every payload word of its frame, and `wr_offset` moves in the same cycle as the header write.
- R6: The read register resets to 0xFFF0. The read position is (register + 16) modulo the ring length, and `buf_empty` is high exactly when it equals `wr_offset`.
- R7: A frame whose entry size is not strictly smaller than the free space is dropped. Free space is (read − write) modulo the ring length, or the full ring length when the two positions are equal. A drop sets `int_status` bit 4, adds one to `missed_cnt` (saturating) and leaves `wr_offset` unchanged.
- R8: A frame longer than CAP bytes (2047) is dropped. Its remaining bytes are still accepted. The drop sets `int_status` bit 6 and adds one to `missed_cnt`.
- R9: Each committed entry sets `int_status` bit 0.
- R10: A write to the status register with a 1 in a bit clears it, and a 0 leaves it. A set in the same cycle wins over a clear.
- R11: With `cfg_keep_bad` low, a frame with any of status bits 1 to 5 is discarded, with no commit and no status bit. With `cfg_keep_bad` high, it is committed like a good frame.
- R12: After reset, `wr_offset` is 0, `int_status` is 0, `missed_cnt` is 0 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_idx | input | 2 | Ring length selector |
| cfg_keep_bad | input | 1 | Store frames with errors |
| s_valid | input | 1 | Byte valid |
| s_ready | output | 1 | Byte accepted when high with valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Last byte of frame |
| s_crc_err | input | 1 | CRC error flag, sampled with last |
| s_align_err | input | 1 | Alignment error flag, sampled with last |
| s_sym_err | input | 1 | Symbol error flag, sampled with last |
| s_bcast | input | 1 | Broadcast destination, sampled with last |
| s_phys | input | 1 | Own-address match, sampled with last |
| s_mcast | input | 1 | Multicast destination, sampled with last |
| rdptr_we | input | 1 | Load the read register |
| rdptr_wdata | input | 16 | Read position minus 16 |
| int_clr_we | input | 1 | Write-one-to-clear strobe |
| int_clr_data | input | 16 | Bits to clear |
| int_status | output | 16 | Sticky status (bits 0, 4, 6) |
| buf_empty | output | 1 | No unread entry |
| wr_offset | output | 15 | Start of the next entry |
| missed_cnt | output | 24 | Dropped-frame count |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 15 | Byte address of the word |
| mem_wdata | output | 32 | Word written |

## Verification
On every cycle, the assertions check the following. Memory writes are word aligned. The write offset stays inside the selected ring and only moves together with a header write at the old offset. A receive-done set shows in the status bit the next cycle and a lone clear removes it. The missed counter only ever steps by one. Only the bench scenarios can show the contents of entries: the header fields, byte order, zero padding and wrap-around at the ring end. They also cover the choice between commit and drop against the live read position, the quiet discard of bad frames and the ring-size selection, all compared with a model of free space in the bench.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int STB_OK    = 0;
  localparam int STB_ALIGN = 1;
  localparam int STB_CRC   = 2;
  localparam int STB_LONG  = 3;
  localparam int STB_RUNT  = 4;
  localparam int STB_SYM   = 5;
  localparam int STB_BCAST = 13;
  localparam int STB_PHYS  = 14;
  localparam int STB_MCAST = 15;

  localparam int IRB_DONE  = 0;
  localparam int IRB_OVF   = 4;
  localparam int IRB_FOVF  = 6;

  typedef enum logic [1:0] {
    WS_RUN  = 2'd0,
    WS_DROP = 2'd1,
    WS_HDR  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int RING_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        len_idx,
  input  logic [RING_W-1:0] wr_off,
  input  logic [RING_W:0]   rd_reg,
  output logic [RING_W-1:0] ring_mask,
  output logic [RING_W:0]   free_bytes,
  output logic              empty
);
  localparam int OFF_W    = RING_W + 1;
  localparam int BASE_LEN = 1 << (RING_W - 2);

  logic [1:0]       sel;
  logic [OFF_W-1:0] ring_len;
  logic [OFF_W-1:0] mask_ext;
  logic [OFF_W-1:0] rd_pos;
  logic [OFF_W-1:0] diff;

  always_comb begin
    sel       = (len_idx > 2'd2) ? 2'd2 : len_idx;
    ring_len  = OFF_W'(BASE_LEN) << sel;
    mask_ext  = ring_len - OFF_W'(1);
    ring_mask = mask_ext[RING_W-1:0];
    rd_pos    = (rd_reg + OFF_W'(16)) & mask_ext;
    diff      = (rd_pos - {1'b0, wr_off}) & mask_ext;
    empty     = (diff == '0);
    free_bytes = empty ? ring_len : diff;
  end

  assert_offset_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, wr_off} < ring_len);
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               din,
  output logic [8*LANES-1:0]       word_next
);
  localparam int LW = $clog2(LANES);

  logic [8*LANES-1:0] acc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (lane == LW'(g))
        word_next[8*g +: 8] = din;
      else if (lane == '0)
        word_next[8*g +: 8] = 8'h00;
      else
        word_next[8*g +: 8] = acc_q[8*g +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= word_next;
  end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
  parameter int MISS_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       set_vec,
  input  logic              bump,
  input  logic              clr_we,
  input  logic [15:0]       clr_data,
  output logic [15:0]       status,
  output logic [MISS_W-1:0] missed
);
  logic [15:0] clr_mask;

  always_comb clr_mask = clr_we ? clr_data : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      missed <= '0;
    end else begin
      status <= set_vec | (status & ~clr_mask);
      if (bump && (missed != '1)) missed <= missed + MISS_W'(1);
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> status[0]);
  assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[0] && !set_vec[0]) |=> !status[0]);
  assert_missed_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed) |-> (missed == $past(missed) + MISS_W'(1)));
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int RING_W  = 15,
  parameter int CAP     = 2047,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int MISS_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len_idx,
  input  logic              cfg_keep_bad,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              s_crc_err,
  input  logic              s_align_err,
  input  logic              s_sym_err,
  input  logic              s_bcast,
  input  logic              s_phys,
  input  logic              s_mcast,
  input  logic              rdptr_we,
  input  logic [RING_W:0]   rdptr_wdata,
  input  logic              int_clr_we,
  input  logic [15:0]       int_clr_data,
  output logic [15:0]       int_status,
  output logic              buf_empty,
  output logic [RING_W-1:0] wr_offset,
  output logic [MISS_W-1:0] missed_cnt,
  output logic              mem_we,
  output logic [RING_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int CNT_W = $clog2(CAP + 2);
  localparam int OFF_W = RING_W + 1;

  wr_state_e         state_q;
  logic [CNT_W-1:0]  idx_q, cnt_now, hdr_count_q;
  logic [15:0]       hdr_status_q, stat_now;
  logic [RING_W-1:0] wr_off_q, ring_mask, data_addr, next_wr;
  logic [OFF_W-1:0]  free_bytes, dword_off, entry_size, sum_d, sum_w;
  logic [RING_W:0]   rdptr_q;
  logic [31:0]       word_next;
  logic              accept, run_take, flush, no_room, cap_hit, runt, too_long, bad;
  logic              go_fovf, go_ovf, do_data, end_ok;
  logic [15:0]       set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)        rdptr_q <= OFF_W'(16'hFFF0);
    else if (rdptr_we) rdptr_q <= rdptr_wdata;
  end

  rxr_space #(.RING_W(RING_W)) u_space (
    .clk(clk), .rst_n(rst_n), .len_idx(cfg_len_idx), .wr_off(wr_off_q),
    .rd_reg(rdptr_q), .ring_mask(ring_mask), .free_bytes(free_bytes), .empty(buf_empty)
  );

  assign s_ready  = (state_q != WS_HDR);
  assign accept   = s_valid && s_ready;
  assign run_take = accept && (state_q == WS_RUN);

  rxr_pack #(.LANES(4)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(run_take), .lane(idx_q[1:0]),
    .din(s_data), .word_next(word_next)
  );

  always_comb begin
    dword_off  = OFF_W'({idx_q[CNT_W-1:2], 2'b00}) + OFF_W'(4);
    no_room    = (dword_off + OFF_W'(4)) >= free_bytes;
    cap_hit    = (idx_q == CNT_W'(CAP));
    flush      = (idx_q[1:0] == 2'd3) || s_last;
    cnt_now    = idx_q + CNT_W'(1);
    runt       = cnt_now < CNT_W'(MIN_LEN);
    too_long   = cnt_now > CNT_W'(MAX_LEN);
    bad        = s_crc_err | s_align_err | s_sym_err | runt | too_long;
    stat_now   = '0;
    stat_now[STB_OK]    = !bad;
    stat_now[STB_ALIGN] = s_align_err;
    stat_now[STB_CRC]   = s_crc_err;
    stat_now[STB_LONG]  = too_long;
    stat_now[STB_RUNT]  = runt;
    stat_now[STB_SYM]   = s_sym_err;
    stat_now[STB_BCAST] = s_bcast;
    stat_now[STB_PHYS]  = s_phys;
    stat_now[STB_MCAST] = s_mcast;

    go_fovf = run_take && cap_hit;
    go_ovf  = run_take && !cap_hit && flush && no_room;
    do_data = run_take && !cap_hit && flush && !no_room;
    end_ok  = do_data && s_last && (!bad || cfg_keep_bad);

    sum_d      = {1'b0, wr_off_q} + dword_off;
    data_addr  = sum_d[RING_W-1:0] & ring_mask;
    entry_size = (OFF_W'(hdr_count_q) + OFF_W'(7)) & ~OFF_W'(3);
    sum_w      = {1'b0, wr_off_q} + entry_size;
    next_wr    = sum_w[RING_W-1:0] & ring_mask;

    set_vec = '0;
    set_vec[IRB_DONE] = (state_q == WS_HDR);
    set_vec[IRB_OVF]  = go_ovf;
    set_vec[IRB_FOVF] = go_fovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= WS_RUN;
      idx_q        <= '0;
      hdr_count_q  <= '0;
      hdr_status_q <= '0;
      wr_off_q     <= '0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state_q)
        WS_RUN: if (accept) begin
          if (go_fovf || go_ovf) begin
            idx_q   <= '0;
            state_q <= s_last ? WS_RUN : WS_DROP;
          end else if (s_last) begin
            idx_q   <= '0;
            state_q <= end_ok ? WS_HDR : WS_RUN;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        WS_DROP: if (accept && s_last) state_q <= WS_RUN;
        WS_HDR: begin
          state_q   <= WS_RUN;
          mem_we    <= 1'b1;
          mem_addr  <= wr_off_q;
          mem_wdata <= {16'(hdr_count_q), hdr_status_q};
          wr_off_q  <= next_wr;
        end
        default: state_q <= WS_RUN;
      endcase
      if (do_data) begin
        mem_we    <= 1'b1;
        mem_addr  <= data_addr;
        mem_wdata <= word_next;
      end
      if (end_ok) begin
        hdr_count_q  <= cnt_now;
        hdr_status_q <= stat_now;
      end
    end
  end

  rxr_irq #(.MISS_W(MISS_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .bump(go_ovf || go_fovf),
    .clr_we(int_clr_we), .clr_data(int_clr_data), .status(int_status), .missed(missed_cnt)
  );

  assign wr_offset = wr_off_q;

  assert_dword_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00));
  assert_commit_with_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_off_q) |-> (mem_we && (mem_addr == $past(wr_off_q))));
endmodule

// File: tb/rxr_writer_test.sv
module rxr_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 2047;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_len_idx = 2'd0;
  logic cfg_keep_bad = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = 8'h00;
  logic s_crc_err = 0, s_align_err = 0, s_sym_err = 0, s_bcast = 0, s_phys = 0, s_mcast = 0;
  logic rdptr_we = 0, int_clr_we = 0;
  logic [15:0] rdptr_wdata = 16'h0, int_clr_data = 16'h0;
  logic [15:0] int_status;
  logic buf_empty, mem_we;
  logic [14:0] wr_offset, mem_addr;
  logic [23:0] missed_cnt;
  logic [31:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_writer uut (
    .clk(clk), .rst_n(rst_n), .cfg_len_idx(cfg_len_idx), .cfg_keep_bad(cfg_keep_bad),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_crc_err(s_crc_err), .s_align_err(s_align_err), .s_sym_err(s_sym_err),
    .s_bcast(s_bcast), .s_phys(s_phys), .s_mcast(s_mcast),
    .rdptr_we(rdptr_we), .rdptr_wdata(rdptr_wdata), .int_clr_we(int_clr_we),
    .int_clr_data(int_clr_data), .int_status(int_status), .buf_empty(buf_empty),
    .wr_offset(wr_offset), .missed_cnt(missed_cnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [31:0] mem [0:2047];
  always @(posedge clk) if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int exp_w, exp_r, ring_l, exp_miss;
  logic [15:0] exp_irq;
  logic [7:0] pay [0:2299];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rd_byte(int off);
    int o = off % ring_l;
    return mem[(o >> 2) % 2048][8*(o%4) +: 8];
  endfunction

  function automatic int free_space();
    int f = ((exp_r - exp_w) % ring_l + ring_l) % ring_l;
    return (f == 0) ? ring_l : f;
  endfunction

  task automatic do_reset(logic [1:0] idx);
    @(negedge clk);
    rst_n = 0; cfg_len_idx = idx;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_w = 0; exp_r = 0; exp_irq = 0; exp_miss = 0;
    ring_l = 8192 << ((idx > 2) ? 2 : idx);
  endtask

  task automatic put(logic [7:0] b, logic last);
    s_valid = 1; s_data = b; s_last = last;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic consume();
    exp_r = exp_w;
    rdptr_we = 1; rdptr_wdata = 16'(exp_r + 16'hFFF0);
    @(negedge clk);
    rdptr_we = 0;
  endtask

  task automatic clr_irq(logic [15:0] v);
    int_clr_we = 1; int_clr_data = v;
    @(negedge clk);
    int_clr_we = 0;
  endtask

  task automatic send_frame(int n, bit crc, bit al, bit sym, bit bc, bit ph, bit mc, bit chkmem);
    int sz, start;
    bit bad, commit;
    logic [15:0] st;
    bit ok;
    sz = (n + 7) & ~3;
    start = exp_w;
    bad = crc | al | sym | (n < 64) | (n > 1518);
    st = 16'h0;
    st[0] = !bad; st[1] = al; st[2] = crc; st[3] = (n > 1518); st[4] = (n < 64);
    st[5] = sym; st[13] = bc; st[14] = ph; st[15] = mc;
    commit = 0;
    if (n > CAP) begin exp_irq[6] = 1; exp_miss++; end
    else if (sz >= free_space()) begin exp_irq[4] = 1; exp_miss++; end
    else if (bad && !cfg_keep_bad) begin end
    else begin commit = 1; exp_w = (exp_w + sz) % ring_l; exp_irq[0] = 1; end
    s_crc_err = crc; s_align_err = al; s_sym_err = sym; s_bcast = bc; s_phys = ph; s_mcast = mc;
    for (int k = 0; k < n; k++) begin
      pay[k] = 8'($urandom);
      put(pay[k], k == n - 1);
    end
    // R1: header cycle holds off the stream
    if (commit) chk(s_ready == 0, "R1 ready low during header", 32'(s_ready), 0);
    repeat (3) @(negedge clk);
    chk(wr_offset == 15'(exp_w), "R4/R7 wr_offset", 32'(wr_offset), 32'(exp_w));
    chk(int_status == exp_irq, "R9/R7/R8 int_status", 32'(int_status), 32'(exp_irq));
    chk(missed_cnt == 24'(exp_miss), "R7/R8 missed_cnt", 32'(missed_cnt), 32'(exp_miss));
    chk(buf_empty == (exp_w == exp_r), "R6 buf_empty", 32'(buf_empty), 32'(exp_w == exp_r));
    if (commit && chkmem) begin
      logic [31:0] hdr;
      hdr = {rd_byte(start+3), rd_byte(start+2), rd_byte(start+1), rd_byte(start)};
      chk(hdr == {16'(n), st}, "R2/R3 header word", hdr, {16'(n), st});
      ok = 1;
      for (int k = 0; k < n; k++) if (rd_byte(start + 4 + k) != pay[k]) ok = 0;
      chk(ok, "R2 payload bytes", 32'(ok), 1);
      ok = 1;
      for (int k = 4 + n; k < sz; k++) if (rd_byte(start + k) != 8'h00) ok = 0;
      chk(ok, "R2 zero padding", 32'(ok), 1);
    end
    clr_irq(16'h0051);
    exp_irq = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    do_reset(2'd0);
    @(negedge clk);
    // R12 reset state
    chk(wr_offset == 0, "R12 wr_offset reset", 32'(wr_offset), 0);
    chk(int_status == 0, "R12 int_status reset", 32'(int_status), 0);
    chk(missed_cnt == 0, "R12 missed reset", 32'(missed_cnt), 0);
    chk(buf_empty == 1, "R12/R6 empty at reset", 32'(buf_empty), 1);
    chk(s_ready == 1, "R1 ready at reset", 32'(s_ready), 1);

    // R2 R3 R9 good frame with odd length
    send_frame(67, 0, 0, 0, 1, 0, 0, 1);
    chk(buf_empty == 0, "R6 not empty after commit", 32'(buf_empty), 0);
    consume();
    chk(buf_empty == 1, "R6 empty after consume", 32'(buf_empty), 1);

    // R10 write-one-to-clear: zero leaves, one clears
    send_frame(64, 0, 0, 0, 0, 1, 0, 1);
    consume();
    s_valid = 0;
    for (int k = 0; k < 64; k++) put(8'(k), k == 63);
    repeat (3) @(negedge clk);
    exp_w = (exp_w + 68) % ring_l;
    clr_irq(16'h0000);
    chk(int_status[0] == 1, "R10 zero write leaves bit", 32'(int_status), 1);
    clr_irq(16'h0001);
    chk(int_status == 0, "R10 one write clears bit", 32'(int_status), 0);
    consume();

    // R11 bad frames: discard, then keep
    cfg_keep_bad = 0;
    send_frame(100, 1, 0, 0, 0, 0, 1, 1);
    send_frame(40, 0, 0, 0, 0, 0, 0, 1);
    cfg_keep_bad = 1;
    send_frame(50, 0, 1, 1, 0, 0, 1, 1);
    send_frame(1530, 1, 0, 0, 0, 1, 0, 1);
    consume();
    cfg_keep_bad = 0;

    // R4 wrap across ring end, R7 overflow when not consumed
    while (exp_w + 1004 < ring_l) begin send_frame(1000, 0, 0, 0, 0, 1, 0, 1); consume(); end
    send_frame(1000, 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 9; i++) send_frame(1000, 0, 0, 0, 0, 0, 0, 1);
    consume();

    // R8 length cap
    do_reset(2'd0);
    send_frame(2100, 0, 0, 0, 0, 0, 0, 0);
    send_frame(80, 0, 0, 0, 0, 0, 0, 1);
    consume();

    // random mix
    for (int i = 0; i < 60; i++) begin
      int n;
      bit e;
      n = 60 + int'($urandom % 500);
      e = ($urandom % 8) == 0;
      cfg_keep_bad = 1'($urandom);
      send_frame(n, e, 0, ($urandom % 16) == 0, 1'($urandom), 1'($urandom), 1'($urandom), 1);
      if ($urandom % 3 != 0) consume();
    end

    // R4 larger ring: offsets pass 8192 and wrap at 16384
    do_reset(2'd1);
    for (int i = 0; i < 17; i++) begin
      send_frame(1000, 0, 0, 0, 0, 0, 0, 0);
      consume();
    end
    chk(wr_offset == 15'd684, "R4 16K ring wrap", 32'(wr_offset), 684);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule